// File: doc/BRIEF.md
# Debug Console Address Register

This block keeps the target address used by a debug console when it reads or writes words inside a processor system. The host loads it through three small registers. The first sets the low half of the word address. The second sets the upper address bits and two mapping flags. The third sets a base and a byte-enable pattern that are used when the console reaches the peripheral register page instead of ordinary memory.

Each console command picks one of two addressing modes. In normal mode the stored memory address is presented. In peripheral mode the address is assembled from a fixed page pattern, the stored base and a small per-command offset. A separate pulse, sent when a streamed access finishes, advances the stored word address by one. All outputs are registered. They reflect a register write, a command or a step on the clock edge that accepts it.

Top module: `con_addr_reg`

## Requirements
- R1: A register write with select 0 clears byte-address bits 21..16 and both mapping flags, then loads byte-address bits 15..1 from data bits 15..1. Data bit 0 is dropped.
- R2: A register write with select 1 loads byte-address bits 21..16 from data bits 5..0, the 22-bit-enable flag from data bit 6 and the map-enable flag from data bit 7. Byte-address bits 15..1 are kept.
- R3: A register write with select 2 stores a 7-bit peripheral base from data bits 12..6 and a byte enable from data bits 1..0. A written byte enable of 00 is stored as 11.
- R4: In peripheral mode the output word address carries 111 in byte-address bits 15..13, the stored base in bits 12..6 and command offset bits 5..1 in bits 5..1. Bits 21..16 are zero and offset bit 0 is ignored.
- R5: In peripheral mode the remote-access flag is 1, both mapping flags are 0 and the byte enable is the stored peripheral byte enable.
- R6: In normal mode the output is the stored word address with byte enable 11, remote-access 0 and the stored mapping flags.
- R7: A step pulse adds one to the stored word address. The carry passes from bit 15 into bit 16, and the address wraps to zero from all ones. The step does this in either mode.
- R8: A select-0 or select-1 write in the same cycle as a step takes precedence and the step is dropped. A write with select 3 changes nothing.
- R9: A synchronous active-high reset clears the address, the mapping flags, the base and the mode to normal, and sets the stored peripheral byte enable to 11.
- R10: A command pulse latches the mode and offset, and these hold until the next command. Every output changes on the clock edge that accepts the write, command or step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 2 | Register select: 0 low, 1 high/flags, 2 peripheral base, 3 none |
| reg_wdata | input | 16 | Register write data |
| cmd_go | input | 1 | Command strobe; latches mode and offset |
| cmd_periph | input | 1 | 1 selects peripheral-page addressing for the command |
| cmd_off | input | 6 | Byte offset within the peripheral page |
| step_go | input | 1 | Streamed access finished; advance stored address |
| out_waddr | output | 21 | Word address (byte-address bits 21..1) |
| out_be | output | 2 | Byte enable |
| out_remote | output | 1 | Remote (peripheral-page) access flag |
| out_ena22 | output | 1 | 22-bit mapping enable |
| out_map | output | 1 | Bus-map enable |

## Verification
The assertions run on every cycle. They check how each register write lands in the stored fields, that a stored peripheral byte enable is never 00, how the outputs are formed in each mode from the stored state, the single increment per accepted step, and the reset values. Some behaviours are visible only through the bench's scenarios. These are the carry from bit 15 into bit 16, the wrap from all ones, a select-3 write leaving everything unchanged, and a write overriding a step in the same cycle. The bench also shows that an increment made while in peripheral mode appears once a later command returns to normal mode.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;
  localparam int DATA_W   = 16;
  localparam int WA_W     = 21;   // word address, byte bits 21..1
  localparam int LOW_W    = DATA_W - 1;
  localparam int HI_W     = WA_W - LOW_W;
  localparam int BASE_W   = 7;
  localparam int BASE_LSB = 6;    // data and byte-address position of base
  localparam int OFF_W    = 6;
  localparam int BE_W     = 2;
  localparam int PAGE_W   = 3;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } cpa_sel_e;

  function automatic logic [WA_W-1:0] f_step(input logic [WA_W-1:0] a);
    return a + {{(WA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [BE_W-1:0] f_fix_be(input logic [BE_W-1:0] be);
    return (be == '0) ? {BE_W{1'b1}} : be;
  endfunction

  function automatic logic [WA_W-1:0] f_page_waddr(
    input logic [BASE_W-1:0] base,
    input logic [OFF_W-1:0]  off
  );
    logic [WA_W-1:0] r;
    r = '0;
    r[BASE_LSB+BASE_W-1 +: PAGE_W] = {PAGE_W{1'b1}};
    r[BASE_LSB-1 +: BASE_W]        = base;
    r[OFF_W-2:0]                   = off[OFF_W-1:1];
    return r;
  endfunction
endpackage

// File: rtl/cpa_store.sv
`timescale 1ns/1ps
module cpa_store
  import cpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [WA_W-1:0]   waddr_q,
  output logic              e22_q,
  output logic              map_q,
  output logic [BASE_W-1:0] base_q,
  output logic [BE_W-1:0]   pbe_q,
  output logic [WA_W-1:0]   waddr_nx,
  output logic              e22_nx,
  output logic              map_nx,
  output logic [BASE_W-1:0] base_nx,
  output logic [BE_W-1:0]   pbe_nx,
  output logic              low_wr,
  output logic              high_wr,
  output logic              base_wr,
  output logic              step_take
);
  always_comb begin
    low_wr    = wr && (sel == SEL_LOW);
    high_wr   = wr && (sel == SEL_HIGH);
    base_wr   = wr && (sel == SEL_BASE);
    step_take = step && !low_wr && !high_wr;

    waddr_nx = waddr_q;
    e22_nx   = e22_q;
    map_nx   = map_q;
    base_nx  = base_q;
    pbe_nx   = pbe_q;

    if (low_wr) begin
      waddr_nx            = '0;
      waddr_nx[LOW_W-1:0] = wdata[DATA_W-1:1];
      e22_nx              = 1'b0;
      map_nx              = 1'b0;
    end else if (high_wr) begin
      waddr_nx[WA_W-1:LOW_W] = wdata[HI_W-1:0];
      e22_nx                 = wdata[HI_W];
      map_nx                 = wdata[HI_W+1];
    end else if (step_take) begin
      waddr_nx = f_step(waddr_q);
    end

    if (base_wr) begin
      base_nx = wdata[BASE_LSB +: BASE_W];
      pbe_nx  = f_fix_be(wdata[BE_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr_q <= '0;
      e22_q   <= 1'b0;
      map_q   <= 1'b0;
      base_q  <= '0;
      pbe_q   <= {BE_W{1'b1}};
    end else begin
      waddr_q <= waddr_nx;
      e22_q   <= e22_nx;
      map_q   <= map_nx;
      base_q  <= base_nx;
      pbe_q   <= pbe_nx;
    end
  end
endmodule

// File: rtl/cpa_mode.sv
`timescale 1ns/1ps
module cpa_mode
  import cpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             periph,
  input  logic [OFF_W-1:0] off,
  output logic             mode_q,
  output logic [OFF_W-1:0] off_q,
  output logic             mode_nx,
  output logic [OFF_W-1:0] off_nx
);
  always_comb begin
    mode_nx = cmd ? periph : mode_q;
    off_nx  = cmd ? off    : off_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      off_q  <= '0;
    end else begin
      mode_q <= mode_nx;
      off_q  <= off_nx;
    end
  end
endmodule

// File: rtl/cpa_compose.sv
`timescale 1ns/1ps
module cpa_compose
  import cpa_pkg::*;
(
  input  logic              periph,
  input  logic [OFF_W-1:0]  off,
  input  logic [WA_W-1:0]   waddr,
  input  logic              e22,
  input  logic              mapf,
  input  logic [BASE_W-1:0] base,
  input  logic [BE_W-1:0]   pbe,
  output logic [WA_W-1:0]   c_waddr,
  output logic [BE_W-1:0]   c_be,
  output logic              c_remote,
  output logic              c_e22,
  output logic              c_map
);
  always_comb begin
    if (periph) begin
      c_waddr  = f_page_waddr(base, off);
      c_be     = pbe;
      c_remote = 1'b1;
      c_e22    = 1'b0;
      c_map    = 1'b0;
    end else begin
      c_waddr  = waddr;
      c_be     = {BE_W{1'b1}};
      c_remote = 1'b0;
      c_e22    = e22;
      c_map    = mapf;
    end
  end
endmodule

// File: rtl/con_addr_reg.sv
`timescale 1ns/1ps
module con_addr_reg
  import cpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cmd_go,
  input  logic              cmd_periph,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic              step_go,
  output logic [WA_W-1:0]   out_waddr,
  output logic [BE_W-1:0]   out_be,
  output logic              out_remote,
  output logic              out_ena22,
  output logic              out_map
);
  logic [WA_W-1:0]   waddr_q, waddr_nx, c_waddr;
  logic              e22_q, e22_nx, map_q, map_nx;
  logic [BASE_W-1:0] base_q, base_nx;
  logic [BE_W-1:0]   pbe_q, pbe_nx, c_be;
  logic              low_wr, high_wr, base_wr, step_take;
  logic              mode_q, mode_nx;
  logic [OFF_W-1:0]  off_q, off_nx;
  logic              c_remote, c_e22, c_map;

  cpa_store u_store (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .step(step_go),
    .waddr_q(waddr_q), .e22_q(e22_q), .map_q(map_q), .base_q(base_q),
    .pbe_q(pbe_q),
    .waddr_nx(waddr_nx), .e22_nx(e22_nx), .map_nx(map_nx),
    .base_nx(base_nx), .pbe_nx(pbe_nx),
    .low_wr(low_wr), .high_wr(high_wr), .base_wr(base_wr),
    .step_take(step_take)
  );

  cpa_mode u_mode (
    .clk(clk), .rst(rst), .cmd(cmd_go), .periph(cmd_periph), .off(cmd_off),
    .mode_q(mode_q), .off_q(off_q), .mode_nx(mode_nx), .off_nx(off_nx)
  );

  // Outputs are built from next-state values so they move with the state.
  cpa_compose u_compose (
    .periph(mode_nx), .off(off_nx), .waddr(waddr_nx), .e22(e22_nx),
    .mapf(map_nx), .base(base_nx), .pbe(pbe_nx),
    .c_waddr(c_waddr), .c_be(c_be), .c_remote(c_remote), .c_e22(c_e22),
    .c_map(c_map)
  );

  logic unused_off0;
  assign unused_off0 = off_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_waddr  <= '0;
      out_be     <= {BE_W{1'b1}};
      out_remote <= 1'b0;
      out_ena22  <= 1'b0;
      out_map    <= 1'b0;
    end else begin
      out_waddr  <= c_waddr;
      out_be     <= c_be;
      out_remote <= c_remote;
      out_ena22  <= c_e22;
      out_map    <= c_map;
    end
  end
endmodule

// File: rtl/cpa_checker.sv
`timescale 1ns/1ps
module cpa_checker
  import cpa_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              low_wr,
  input logic              high_wr,
  input logic              base_wr,
  input logic              step_take,
  input logic [WA_W-1:0]   waddr_q,
  input logic              e22_q,
  input logic              map_q,
  input logic [BE_W-1:0]   pbe_q,
  input logic              mode_q,
  input logic [WA_W-1:0]   out_waddr,
  input logic [BE_W-1:0]   out_be,
  input logic              out_remote,
  input logic              out_ena22,
  input logic              out_map
);
  p_low_load_r1: assert property (@(posedge clk) disable iff (rst)
    low_wr |=> (waddr_q[WA_W-1:LOW_W] == '0) && !e22_q && !map_q &&
               (waddr_q[LOW_W-1:0] == $past(reg_wdata[DATA_W-1:1])));

  p_high_load_r2: assert property (@(posedge clk) disable iff (rst)
    high_wr |=> (waddr_q[WA_W-1:LOW_W] == $past(reg_wdata[HI_W-1:0])) &&
                (e22_q == $past(reg_wdata[HI_W])) &&
                (map_q == $past(reg_wdata[HI_W+1])) &&
                (waddr_q[LOW_W-1:0] == $past(waddr_q[LOW_W-1:0])));

  p_be_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (pbe_q != 2'b00));

  p_page_addr_r4: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (out_waddr[14:12] == 3'b111) && (out_waddr[WA_W-1:15] == '0));

  p_page_flags_r5: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> out_remote && !out_ena22 && !out_map && (out_be == pbe_q));

  p_normal_out_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (out_waddr == waddr_q) && (out_be == 2'b11) && !out_remote &&
                (out_ena22 == e22_q) && (out_map == map_q));

  p_step_inc_r7: assert property (@(posedge clk) disable iff (rst)
    step_take |=> (waddr_q == $past(waddr_q) + 21'd1));

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (waddr_q == '0) && !mode_q && (pbe_q == 2'b11) &&
            (out_be == 2'b11) && !out_remote && !out_ena22 && !out_map);
endmodule

bind con_addr_reg cpa_checker u_chk (
  .clk(clk), .rst(rst), .reg_wdata(reg_wdata),
  .low_wr(low_wr), .high_wr(high_wr), .base_wr(base_wr),
  .step_take(step_take), .waddr_q(waddr_q), .e22_q(e22_q), .map_q(map_q),
  .pbe_q(pbe_q), .mode_q(mode_q),
  .out_waddr(out_waddr), .out_be(out_be), .out_remote(out_remote),
  .out_ena22(out_ena22), .out_map(out_map)
);

// File: tb/con_addr_reg_tb.sv
`timescale 1ns/1ps
module con_addr_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic        cmd_go = 1'b0;
  logic        cmd_periph = 1'b0;
  logic [5:0]  cmd_off = 6'h0;
  logic        step_go = 1'b0;
  logic [20:0] out_waddr;
  logic [1:0]  out_be;
  logic        out_remote, out_ena22, out_map;

  always #2.5 clk = ~clk;

  con_addr_reg u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_go(cmd_go), .cmd_periph(cmd_periph),
    .cmd_off(cmd_off), .step_go(step_go), .out_waddr(out_waddr),
    .out_be(out_be), .out_remote(out_remote), .out_ena22(out_ena22),
    .out_map(out_map)
  );

  typedef struct {
    logic [20:0] wa;
    logic [1:0]  be;
    logic        rem;
    logic        e22;
    logic        mp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model, kept as a byte address
  logic [21:0] m_baddr;
  logic        m_e22, m_map, m_per;
  logic [6:0]  m_base;
  logic [1:0]  m_pbe;
  logic [5:0]  m_off;

  task automatic model_reset();
    m_baddr = '0; m_e22 = 0; m_map = 0; m_per = 0;
    m_base = '0; m_pbe = 2'b11; m_off = '0;
  endtask

  function automatic exp_t predict(string tag);
    exp_t e;
    logic [21:0] b;
    e.tag = tag;
    if (m_per) begin
      b = 22'h00E000 | ({15'b0, m_base} << 6) | {16'b0, m_off & 6'h3E};
      e.wa = b[21:1]; e.be = m_pbe; e.rem = 1; e.e22 = 0; e.mp = 0;
    end else begin
      e.wa = m_baddr[21:1]; e.be = 2'b11; e.rem = 0; e.e22 = m_e22; e.mp = m_map;
    end
    return e;
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic act(input logic wr, input logic [1:0] sel, input logic [15:0] d,
                     input logic cmd, input logic per, input logic [5:0] off,
                     input logic st, input string tag);
    bit addr_wr;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d;
    cmd_go = cmd; cmd_periph = per; cmd_off = off; step_go = st;
    addr_wr = wr && (sel == 2'd0 || sel == 2'd1);
    if (wr && sel == 2'd0) begin
      m_baddr = {6'b0, d[15:1], 1'b0}; m_e22 = 0; m_map = 0;
    end
    if (wr && sel == 2'd1) begin
      m_baddr[21:16] = d[5:0]; m_e22 = d[6]; m_map = d[7];
    end
    if (wr && sel == 2'd2) begin
      m_base = d[12:6];
      m_pbe  = (d[1:0] == 2'b00) ? 2'b11 : d[1:0];
    end
    if (st && !addr_wr) m_baddr = m_baddr + 22'd2;
    if (cmd) begin m_per = per; m_off = off; end
    @(posedge clk);
    q.push_back(predict(tag));
  endtask

  task automatic idle(input string tag);
    act(0, 2'd0, 16'h0, 0, 0, 6'h0, 0, tag);
  endtask

  // monitor: compares one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_waddr !== e.wa || out_be !== e.be || out_remote !== e.rem ||
          out_ena22 !== e.e22 || out_map !== e.mp) begin
        fails++;
        $display("FAIL %s: got wa=%h be=%b rem=%b e22=%b map=%b, exp wa=%h be=%b rem=%b e22=%b map=%b",
                 e.tag, out_waddr, out_be, out_remote, out_ena22, out_map,
                 e.wa, e.be, e.rem, e.e22, e.mp);
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle("R9 reset state");

    act(1, 2'd0, 16'h1234, 0, 0, 6'h0, 0, "R1 low write");
    act(1, 2'd1, 16'h00C5, 0, 0, 6'h0, 0, "R2 high write");
    act(1, 2'd0, 16'hABCD, 0, 0, 6'h0, 0, "R1 low clears high");
    act(1, 2'd1, 16'h0040, 0, 0, 6'h0, 0, "R2 flag only");
    act(1, 2'd2, 16'h0FC0, 1, 1, 6'h2A, 0, "R3 be 00 becomes 11, R10 same edge");
    act(0, 2'd0, 16'h0, 1, 1, 6'h15, 0, "R4 odd offset");
    act(1, 2'd2, 16'h1F41, 0, 0, 6'h0, 0, "R5 stored be 01");
    act(0, 2'd0, 16'h0, 0, 0, 6'h0, 1, "R5 step in page mode");
    act(0, 2'd0, 16'h0, 1, 0, 6'h0, 0, "R6 R7 back to normal");

    act(1, 2'd0, 16'hFFFE, 0, 0, 6'h0, 0, "R1 setup carry");
    act(0, 2'd0, 16'h0, 0, 0, 6'h0, 1, "R7 carry into bit 16");
    act(1, 2'd0, 16'hFFFE, 0, 0, 6'h0, 0, "R1 setup wrap");
    act(1, 2'd1, 16'h003F, 0, 0, 6'h0, 0, "R2 setup wrap");
    act(0, 2'd0, 16'h0, 0, 0, 6'h0, 1, "R7 wrap to zero");
    act(1, 2'd0, 16'h0100, 0, 0, 6'h0, 1, "R8 low write beats step");
    act(1, 2'd1, 16'h0081, 0, 0, 6'h0, 1, "R8 high write beats step");
    act(1, 2'd3, 16'hFFFF, 0, 0, 6'h0, 0, "R8 select 3 ignored");
    act(0, 2'd0, 16'h0, 1, 1, 6'h3F, 0, "R8 base untouched by select 3");
    idle("R10 mode held");

    @(negedge clk) rst = 1'b1;
    reg_wr = 0; cmd_go = 0; step_go = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    model_reset();
    idle("R9 reset again");
    act(0, 2'd0, 16'h0, 1, 1, 6'h00, 0, "R9 page defaults after reset");
    idle("R10 final");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule